// File: doc/BRIEF.md
# Locality-Gated Register Access Filter

This block sits between the host bus decoder and the register file of a trusted module. For each decoded register access it decides in the same cycle whether the register file takes the cycle or aborts it. The bus interface uses that decision to choose between sending a SYNC response and letting the master abort the cycle. The decision depends on three things: the register addressed, the direction of the access, and how the requesting locality relates to the locality that currently owns the module. The requester may be the owner, another locality may be the owner, or no locality may own the module.

The block holds the ownership state: a valid bit plus a 3-bit locality number. An accepted access-register write with the request bit grants ownership. An accepted access-register write with the release bit ends it. The hash-start and hash-end registers take and release locality 4 implicitly. For every accepted cycle the block raises exactly one one-hot read or write strobe, which the register file uses as its update enable.

Top module: `locality_access_filter`

## Requirements
- R1: While `acc_valid_i` is high, exactly one of `accept_o` and `abort_o` is high in the same cycle, decided with no clock edge in between. While it is low, both are low. Register codes are: access 0, status 1, interrupt enable 2, interrupt vector 3, interrupt status 4, interrupt capability 5, data FIFO 6, configuration 7, hash start 8, hash data 9, hash end 10. Codes 11 to 15, and localities 5 to 7, are always aborted.
- R2: The status register accepts reads and writes only from the owning locality. All other status accesses are aborted.
- R3: The interrupt enable, interrupt vector and configuration registers accept reads from any locality. They accept writes only from the owning locality.
- R4: The interrupt status register accepts reads from any locality and writes only from the owner; an accepted write raises its write strobe, which clears the interrupt. The interrupt capability register accepts every read and aborts every write.
- R5: The access register accepts reads and writes from any legal locality, whether the requester owns the module, another locality owns it, or nobody owns it.
- R6: A data FIFO read is accepted only from the owner and only while `data_avail_i` is high. A data FIFO write is accepted only from the owner.
- R7: A hash-start write is accepted from the owner, or from any legal locality when nobody owns the module. In the latter case the owner becomes locality 4 one cycle later. Hash-start reads are aborted.
- R8: Hash-data and hash-end writes are accepted only from the owner, and reads of both are aborted. An accepted hash-end write releases ownership when the owner is locality 4. Otherwise ownership is unchanged.
- R9: An accepted access-register write takes effect on ownership as follows. If bit 5 (release) is set and the writer is the owner, ownership is cleared. Otherwise, if bit 1 (request) is set and nobody owns the module, the writer becomes the owner. Release has priority, and a request made while another locality owns the module has no effect.
- R10: After reset, and after any reset applied during operation, nobody owns the module.
- R11: An aborted cycle raises no strobe and leaves ownership unchanged. An accepted cycle raises exactly one bit of `rd_stb_o` (read) or `wr_stb_o` (write), at the index equal to the register code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid_i | input | 1 | Decoded access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_reg_i | input | 4 | Register code (see R1) |
| acc_loc_i | input | 3 | Requesting locality |
| acc_wdata_i | input | 8 | Write data byte |
| data_avail_i | input | 1 | Data-available status flag of the FIFO |
| accept_o | output | 1 | Cycle accepted; SYNC may be sent |
| abort_o | output | 1 | Cycle aborted; no SYNC |
| rd_stb_o | output | 11 | One-hot read strobe per register code |
| wr_stb_o | output | 11 | One-hot write strobe per register code |
| owner_valid_o | output | 1 | A locality owns the module |
| owner_loc_o | output | 3 | Owning locality number |

## Verification
A wrong ownership state shows up on the cycle right after the access that caused it. It appears directly on `owner_valid_o`/`owner_loc_o`, and one access later as a flipped accept/abort on the status, FIFO or hash registers, because their acceptance depends on whether the requester is the owner. A fault in the policy matrix shows within the same cycle as `acc_valid_i`, both as an inverted accept/abort pair and as a missing or extra strobe bit. The vector sequence therefore walks every register through all three ownership relations. It also drives the ownership transitions (grant, ignored request, release priority, implicit take and release of locality 4), so any state error is caught by the next vector.

// File: rtl/lfilt_pkg.sv
// Package: shared widths, register codes, locality relation and ownership
// state type for the locality access filter.
package lfilt_pkg;
    localparam int LOC_W     = 3;
    localparam int REG_W     = 4;
    localparam int NUM_REGS  = 11;
    localparam int MAX_LOC   = 4;
    localparam int HASH_LOC  = 4;

    // Register codes; the strobe index equals the code.
    typedef enum logic [REG_W-1:0] {
        RC_ACCESS   = 4'd0,
        RC_STATUS   = 4'd1,
        RC_INT_EN   = 4'd2,
        RC_INT_VEC  = 4'd3,
        RC_INT_STAT = 4'd4,
        RC_INT_CAP  = 4'd5,
        RC_FIFO     = 4'd6,
        RC_CONFIG   = 4'd7,
        RC_HSTART   = 4'd8,
        RC_HDATA    = 4'd9,
        RC_HEND     = 4'd10
    } reg_code_e;

    // How the requester relates to the current owner.
    typedef enum logic [1:0] {
        REL_NONE   = 2'd0,
        REL_OTHER  = 2'd1,
        REL_OWNER  = 2'd2
    } loc_rel_e;

    typedef struct packed {
        logic             valid;
        logic [LOC_W-1:0] num;
    } owner_t;
endpackage

// File: rtl/lfilt_relation.sv
// Module: lfilt_relation
// Classifies the requesting locality against the ownership state and flags
// whether the requester number is a legal locality.
// Assumes: owner.num is always legal while owner.valid is set.
module lfilt_relation
    import lfilt_pkg::*;
(
    input  logic [LOC_W-1:0] req_loc_i,
    input  owner_t           owner_i,
    output loc_rel_e         rel_o,
    output logic             legal_o
);
    // Purpose: three-way relation and legality of the requester.
    always_comb begin
        legal_o = (int'(req_loc_i) <= MAX_LOC);
        if (!owner_i.valid)
            rel_o = REL_NONE;
        else if (owner_i.num == req_loc_i)
            rel_o = REL_OWNER;
        else
            rel_o = REL_OTHER;
    end
endmodule

// File: rtl/lfilt_policy.sv
// Module: lfilt_policy
// Per-register access matrix: given register, direction, locality relation
// and the FIFO data-available flag, says whether the access is permitted.
// Assumes: legality of the locality is handled by the caller.
module lfilt_policy
    import lfilt_pkg::*;
(
    input  logic [REG_W-1:0] reg_i,
    input  logic             write_i,
    input  loc_rel_e         rel_i,
    input  logic             data_avail_i,
    output logic             permit_o
);
    logic is_owner;
    logic is_none;

    // Purpose: evaluate the matrix row of the addressed register.
    always_comb begin
        is_owner = (rel_i == REL_OWNER);
        is_none  = (rel_i == REL_NONE);
        unique case (reg_i)
            RC_STATUS:                        permit_o = is_owner;
            RC_INT_EN, RC_INT_VEC, RC_CONFIG,
            RC_INT_STAT:                      permit_o = !write_i || is_owner;
            RC_INT_CAP:                       permit_o = !write_i;
            RC_ACCESS:                        permit_o = 1'b1;
            RC_FIFO:                          permit_o = is_owner && (write_i || data_avail_i);
            RC_HSTART:                        permit_o = write_i && (is_owner || is_none);
            RC_HDATA, RC_HEND:                permit_o = write_i && is_owner;
            default:                          permit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lfilt_tracker.sv
// Module: lfilt_tracker
// Holds the ownership state. Applies explicit request/release through the
// access register and the implicit take/release of the hash locality.
// Assumes: commit_i is high only for accepted writes of a legal locality.
module lfilt_tracker
    import lfilt_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int REQ_BIT = 1,
    parameter int REL_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [LOC_W-1:0]  loc_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  loc_rel_e          rel_i,
    output owner_t            owner_o
);
    localparam logic [DATA_W-1:0] REQ_MASK = DATA_W'(1) << REQ_BIT;
    localparam logic [DATA_W-1:0] REL_MASK = DATA_W'(1) << REL_BIT;

    owner_t owner_q;
    owner_t owner_d;
    logic   want_req;
    logic   want_rel;

    // Purpose: next ownership from the committed write.
    always_comb begin
        owner_d  = owner_q;
        want_req = (wdata_i & REQ_MASK) != '0;
        want_rel = (wdata_i & REL_MASK) != '0;
        if (commit_i) begin
            unique case (reg_i)
                RC_ACCESS: begin
                    if (want_rel && rel_i == REL_OWNER)
                        owner_d = '{valid: 1'b0, num: '0};
                    else if (want_req && rel_i == REL_NONE)
                        owner_d = '{valid: 1'b1, num: loc_i};
                end
                RC_HSTART: begin
                    if (rel_i == REL_NONE)
                        owner_d = '{valid: 1'b1, num: LOC_W'(HASH_LOC)};
                end
                RC_HEND: begin
                    if (owner_q.num == LOC_W'(HASH_LOC))
                        owner_d = '{valid: 1'b0, num: '0};
                end
                default: owner_d = owner_q;
            endcase
        end
    end

    // Purpose: ownership register with synchronous reset to "nobody".
    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= '{valid: 1'b0, num: '0};
        else        owner_q <= owner_d;
    end

    assign owner_o = owner_q;

    assert_hstart_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && reg_i == RC_HSTART && rel_i == REL_NONE)
        |=> (owner_q.valid && owner_q.num == LOC_W'(HASH_LOC)));

    assert_hend_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && reg_i == RC_HEND && owner_q.num == LOC_W'(HASH_LOC))
        |=> !owner_q.valid);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && reg_i == RC_ACCESS && wdata_i[REL_BIT] && rel_i == REL_OWNER)
        |=> !owner_q.valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(owner_q));
endmodule

// File: rtl/lfilt_strobes.sv
// Module: lfilt_strobes
// Turns an accepted access into a one-hot read or write strobe indexed by
// the register code.
// Assumes: accept_i is only high for mapped register codes.
module lfilt_strobes
    import lfilt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  logic                write_i,
    input  logic [REG_W-1:0]    reg_i,
    output logic [NUM_REGS-1:0] rd_stb_o,
    output logic [NUM_REGS-1:0] wr_stb_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
        logic hit;
        // Purpose: decode one register's strobe pair.
        always_comb begin
            hit         = accept_i && (reg_i == REG_W'(g));
            rd_stb_o[g] = hit && !write_i;
            wr_stb_o[g] = hit && write_i;
        end
    end

    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_stb_o, wr_stb_o}) && (accept_i || ({rd_stb_o, wr_stb_o} == '0)));
endmodule

// File: rtl/locality_access_filter.sv
// Module: locality_access_filter (top)
// Decides accept/abort for every decoded register access in the same cycle,
// tracks which locality owns the module, and drives per-register strobes.
// Assumes: acc_* inputs are stable while acc_valid_i is high for one cycle.
module locality_access_filter
    import lfilt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid_i,
    input  logic                acc_write_i,
    input  logic [REG_W-1:0]    acc_reg_i,
    input  logic [LOC_W-1:0]    acc_loc_i,
    input  logic [DATA_W-1:0]   acc_wdata_i,
    input  logic                data_avail_i,
    output logic                accept_o,
    output logic                abort_o,
    output logic [NUM_REGS-1:0] rd_stb_o,
    output logic [NUM_REGS-1:0] wr_stb_o,
    output logic                owner_valid_o,
    output logic [LOC_W-1:0]    owner_loc_o
);
    owner_t   owner;
    loc_rel_e rel;
    logic     legal;
    logic     permit;
    logic     commit;

    lfilt_relation u_rel (
        .req_loc_i (acc_loc_i),
        .owner_i   (owner),
        .rel_o     (rel),
        .legal_o   (legal)
    );

    lfilt_policy u_pol (
        .reg_i        (acc_reg_i),
        .write_i      (acc_write_i),
        .rel_i        (rel),
        .data_avail_i (data_avail_i),
        .permit_o     (permit)
    );

    // Purpose: combine legality and policy into the bus decision.
    always_comb begin
        accept_o = acc_valid_i && legal && permit;
        abort_o  = acc_valid_i && !accept_o;
        commit   = accept_o && acc_write_i;
    end

    lfilt_tracker #(.DATA_W(DATA_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .reg_i    (acc_reg_i),
        .loc_i    (acc_loc_i),
        .wdata_i  (acc_wdata_i),
        .rel_i    (rel),
        .owner_o  (owner)
    );

    lfilt_strobes u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept_o),
        .write_i  (acc_write_i),
        .reg_i    (acc_reg_i),
        .rd_stb_o (rd_stb_o),
        .wr_stb_o (wr_stb_o)
    );

    assign owner_valid_o = owner.valid;
    assign owner_loc_o   = owner.num;

    assert_decision_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i ? (accept_o != abort_o) : !(accept_o || abort_o));

    assert_status_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && acc_reg_i == RC_STATUS) |-> (owner.valid && owner.num == acc_loc_i));

    assert_cap_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_write_i && acc_reg_i == RC_INT_CAP) |-> abort_o);

    assert_fifo_avail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !acc_write_i && acc_reg_i == RC_FIFO) |-> data_avail_i);
endmodule

// File: tb/test_locality_access_filter.sv
module test_locality_access_filter;
    localparam int NR = 11;
    localparam int NV = 39;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [3:0]    acc_reg = '0;
    logic [2:0]    acc_loc = '0;
    logic [7:0]    acc_wdata = '0;
    logic          data_avail = 1'b0;
    logic          accept, abort_s, own_v;
    logic [2:0]    own_l;
    logic [NR-1:0] rd_stb, wr_stb;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    locality_access_filter i_locality_access_filter (
        .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
        .acc_reg_i(acc_reg), .acc_loc_i(acc_loc), .acc_wdata_i(acc_wdata),
        .data_avail_i(data_avail), .accept_o(accept), .abort_o(abort_s),
        .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .owner_valid_o(own_v), .owner_loc_o(own_l)
    );

    // Vector: {req[25:22], reg[21:18], wr[17], loc[16:14], wdata[13:6],
    //          avail[5], exp_accept[4], exp_owner_valid[3], exp_owner_loc[2:0]}
    localparam logic [25:0] VEC [NV] = '{
        {4'd2, 4'd1, 1'b0,3'd0,8'h00,1'b0, 1'b0,1'b0,3'd0}, // R2 status rd, none
        {4'd3, 4'd2, 1'b1,3'd1,8'h00,1'b0, 1'b0,1'b0,3'd0}, // R3 int_en wr, none
        {4'd3, 4'd2, 1'b0,3'd1,8'h00,1'b0, 1'b1,1'b0,3'd0}, // R3 int_en rd, none
        {4'd4, 4'd5, 1'b0,3'd2,8'h00,1'b0, 1'b1,1'b0,3'd0}, // R4 cap rd
        {4'd6, 4'd6, 1'b1,3'd0,8'h00,1'b0, 1'b0,1'b0,3'd0}, // R6 fifo wr, none
        {4'd7, 4'd8, 1'b0,3'd0,8'h00,1'b0, 1'b0,1'b0,3'd0}, // R7 hstart rd
        {4'd9, 4'd0, 1'b1,3'd2,8'h02,1'b0, 1'b1,1'b1,3'd2}, // R9 request loc2
        {4'd9, 4'd0, 1'b1,3'd3,8'h02,1'b0, 1'b1,1'b1,3'd2}, // R9 request ignored
        {4'd2, 4'd1, 1'b0,3'd2,8'h00,1'b0, 1'b1,1'b1,3'd2}, // R2 owner rd
        {4'd2, 4'd1, 1'b1,3'd3,8'hFF,1'b0, 1'b0,1'b1,3'd2}, // R2 other wr
        {4'd3, 4'd2, 1'b1,3'd3,8'h00,1'b0, 1'b0,1'b1,3'd2}, // R3 other wr
        {4'd3, 4'd2, 1'b1,3'd2,8'h00,1'b0, 1'b1,1'b1,3'd2}, // R3 owner wr
        {4'd4, 4'd4, 1'b1,3'd3,8'h01,1'b0, 1'b0,1'b1,3'd2}, // R4 int_stat other wr
        {4'd4, 4'd4, 1'b1,3'd2,8'h01,1'b0, 1'b1,1'b1,3'd2}, // R4 int_stat owner wr
        {4'd4, 4'd5, 1'b1,3'd2,8'h00,1'b0, 1'b0,1'b1,3'd2}, // R4 cap wr
        {4'd6, 4'd6, 1'b0,3'd2,8'h00,1'b0, 1'b0,1'b1,3'd2}, // R6 fifo rd no data
        {4'd6, 4'd6, 1'b0,3'd2,8'h00,1'b1, 1'b1,1'b1,3'd2}, // R6 fifo rd data
        {4'd6, 4'd6, 1'b0,3'd3,8'h00,1'b1, 1'b0,1'b1,3'd2}, // R6 fifo rd other
        {4'd6, 4'd6, 1'b1,3'd2,8'h00,1'b0, 1'b1,1'b1,3'd2}, // R6 fifo wr owner
        {4'd7, 4'd8, 1'b1,3'd3,8'h00,1'b0, 1'b0,1'b1,3'd2}, // R7 hstart other
        {4'd7, 4'd8, 1'b1,3'd2,8'h00,1'b0, 1'b1,1'b1,3'd2}, // R7 hstart owner
        {4'd8, 4'd9, 1'b1,3'd2,8'h00,1'b0, 1'b1,1'b1,3'd2}, // R8 hdata owner wr
        {4'd8, 4'd9, 1'b0,3'd2,8'h00,1'b0, 1'b0,1'b1,3'd2}, // R8 hdata rd
        {4'd8, 4'd10,1'b1,3'd2,8'h00,1'b0, 1'b1,1'b1,3'd2}, // R8 hend, owner not 4
        {4'd3, 4'd7, 1'b1,3'd0,8'h00,1'b0, 1'b0,1'b1,3'd2}, // R3 cfg other wr
        {4'd3, 4'd7, 1'b0,3'd0,8'h00,1'b0, 1'b1,1'b1,3'd2}, // R3 cfg other rd
        {4'd9, 4'd0, 1'b1,3'd3,8'h20,1'b0, 1'b1,1'b1,3'd2}, // R9 release by other
        {4'd9, 4'd0, 1'b1,3'd2,8'h22,1'b0, 1'b1,1'b0,3'd0}, // R9 release wins
        {4'd7, 4'd8, 1'b1,3'd0,8'h00,1'b0, 1'b1,1'b1,3'd4}, // R7 hstart takes 4
        {4'd8, 4'd9, 1'b1,3'd4,8'h00,1'b0, 1'b1,1'b1,3'd4}, // R8 hdata loc4
        {4'd8, 4'd9, 1'b1,3'd0,8'h00,1'b0, 1'b0,1'b1,3'd4}, // R8 hdata other
        {4'd8, 4'd10,1'b0,3'd4,8'h00,1'b0, 1'b0,1'b1,3'd4}, // R8 hend rd
        {4'd8, 4'd10,1'b1,3'd4,8'h00,1'b0, 1'b1,1'b0,3'd0}, // R8 hend releases 4
        {4'd1, 4'd0, 1'b0,3'd5,8'h00,1'b0, 1'b0,1'b0,3'd0}, // R1 illegal locality
        {4'd1, 4'd12,1'b0,3'd0,8'h00,1'b0, 1'b0,1'b0,3'd0}, // R1 unmapped code
        {4'd7, 4'd8, 1'b1,3'd2,8'h00,1'b0, 1'b1,1'b1,3'd4}, // R7 hstart any loc
        {4'd5, 4'd0, 1'b1,3'd4,8'h20,1'b0, 1'b1,1'b0,3'd0}, // R5 access owner wr
        {4'd5, 4'd0, 1'b0,3'd1,8'h00,1'b0, 1'b1,1'b0,3'd0}, // R5 access rd, none
        {4'd3, 4'd3, 1'b0,3'd3,8'h00,1'b0, 1'b1,1'b0,3'd0}  // R3 int_vec rd, none
    };

    task automatic chk(input bit ok, input int req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one access at a falling edge; check the decision before the
    // rising edge, then the ownership after it.
    task automatic do_access(input logic [25:0] v);
        logic [NR-1:0] exp_stb;
        int            rq;
        rq = int'(v[25:22]);
        @(negedge clk);
        acc_valid = 1'b1; acc_reg = v[21:18]; acc_write = v[17];
        acc_loc = v[16:14]; acc_wdata = v[13:6]; data_avail = v[5];
        #2;
        chk(accept == v[4] && abort_s == !v[4], rq, "accept", int'(accept), int'(v[4]));
        exp_stb = v[4] ? NR'(1) << v[21:18] : '0;
        // R11: strobes follow the decision
        chk(wr_stb == (v[17] ? exp_stb : '0) && rd_stb == (v[17] ? '0 : exp_stb),
            11, "strobes", int'({rd_stb, wr_stb}), int'(exp_stb));
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
        chk(own_v == v[3] && (!v[3] || own_l == v[2:0]), rq, "owner",
            int'({own_v, own_l}), int'({v[3], v[2:0]}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: state after reset
        chk(!own_v, 10, "owner after reset", int'(own_v), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: idle gives neither accept nor abort
        chk(!accept && !abort_s, 1, "idle decision", int'({accept, abort_s}), 0);
        for (int i = 0; i < NV; i++) do_access(VEC[i]);
        // R10: reset during ownership clears it
        do_access({4'd9, 4'd0, 1'b1, 3'd1, 8'h02, 1'b0, 1'b1, 1'b1, 3'd1});
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk(!own_v, 10, "owner after mid reset", int'(own_v), 0);
        // R2: status from former owner aborted after reset
        do_access({4'd2, 4'd1, 1'b0, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0});
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule